// File: doc/BRIEF.md
# Multi-select byte-wide static RAM

This block is a clocked model of a small static memory: 128 words of 8 bits, reached through a 7-bit address. There is one data bus, and it is bidirectional. At the block boundary that bus is split into three ports: an input byte, an output byte and an output-enable. Two strobes control access, and both are active low. One is a read enable and the other is a write strobe. Five chip selects gate the whole device. Two of them are active high and three are active low, so a wider memory can be built from several copies by decoding upper address bits onto the selects.

Every rising clock edge samples the selects, the strobes and the address. A decoder turns them into one of four operating states:
- `ST_OFF`: deselected.
- `ST_IDLE`: standby.
- `ST_READ`: read.
- `ST_WRITE`: write.

A state register holds the decoded state, and the next state is simply the decode of the current inputs. Every transition is therefore legal and is named after its target: *deselect* (to `ST_OFF`), *park* (to `ST_IDLE`), *fetch* (to `ST_READ`) and *store* (to `ST_WRITE`). A write commits at the edge that sees the store condition. A read captures the addressed word at the edge that sees the fetch condition, and the word is presented on the bus for the following cycle. Reset clears the state and the read register but leaves the storage untouched.

Top module: `mselect_sram`

## Requirements
- R1: While reset is asserted, and after it is released until a read is sampled, `bus_oe` is 0 and `bus_out` is 0.
- R2: The device is selected only when both bits of `sel_p` are 1 and all three bits of `sel_n` are 0. A single wrong-level bit on either vector prevents any write.
- R3: An edge that samples any select at its inactive level enters `ST_OFF`. `bus_oe` is then 0 and no word is stored, whatever the strobes are.
- R4: An edge that samples the device selected with `rd_n`=0 enters `ST_READ`. In the next cycle `bus_oe` is 1 and `bus_out` holds the word stored at the sampled address.
- R5: An edge that samples the device selected with `rd_n`=1 and `wr_n`=0 stores `bus_in` at the sampled address. `bus_oe` stays 0.
- R6: When both strobes are sampled low while selected, the read is performed and nothing is stored.
- R7: Standby (selected, both strobes high) leaves `bus_oe` at 0 and the stored contents unchanged.
- R8: `bus_out` is 0 in every cycle where `bus_oe` is 0.
- R9: Read data appears one clock after the read is sampled, not before. It stays stable while the read and the address are held, and it follows a new address one clock after the address changes.
- R10: Reset does not clear the storage. A word written before reset is read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of state and read register |
| addr | input | 7 | Word address |
| sel_p | input | 2 | Chip selects, active high |
| sel_n | input | 3 | Chip selects, active low |
| rd_n | input | 1 | Read enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Data into the memory (bus input side) |
| bus_out | output | 8 | Data out of the memory (bus output side) |
| bus_oe | output | 1 | Drive enable for the bus output side |

## Verification
The properties assume that the selects, strobes and address hold known, settled values at each rising edge. They also assume that the address never moves within the same sample as a strobe change, so each edge sees exactly one decoded state. The stimulus changes every input only at the falling clock edge and reads outputs at the following falling edge, half a period clear of any sampling edge. It also only reads back words it has first written, so no expected value depends on the uninitialised array.

// File: rtl/msram_pkg.sv
package msram_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } op_state_e;

endpackage

// File: rtl/msram_decode.sv
module msram_decode
    import msram_pkg::*;
#(
    parameter int NUM_SEL_P = 2,
    parameter int NUM_SEL_N = 3
) (
    input  logic [NUM_SEL_P-1:0] sel_p,
    input  logic [NUM_SEL_N-1:0] sel_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    output op_state_e            op
);

    localparam int NUM_SEL = NUM_SEL_P + NUM_SEL_N;

    logic [NUM_SEL-1:0] sel_ok;
    logic               chip_on;

    // normalise every select to "1 means this select agrees"
    genvar gp;
    generate
        for (gp = 0; gp < NUM_SEL_P; gp++) begin : g_pos
            assign sel_ok[gp] = sel_p[gp];
        end
        for (gp = 0; gp < NUM_SEL_N; gp++) begin : g_neg
            assign sel_ok[NUM_SEL_P + gp] = ~sel_n[gp];
        end
    endgenerate

    assign chip_on = &sel_ok;

    always_comb begin
        if (!chip_on) begin
            op = ST_OFF;
        end else if (!rd_n) begin
            op = ST_READ;            // read wins over a concurrent write strobe
        end else if (!wr_n) begin
            op = ST_WRITE;
        end else begin
            op = ST_IDLE;
        end
    end

endmodule

// File: rtl/msram_array.sv
module msram_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // no reset: contents survive a reset of the control state
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/msram_ctrl.sv
module msram_ctrl
    import msram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_state_e         op_nxt,
    input  logic [DATA_W-1:0] rdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    op_state_e         state_q;
    logic [DATA_W-1:0] word_q;

    // state register: next state is the decoded mode of this sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= op_nxt;
        end
    end

    // read capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (op_nxt == ST_READ) begin
            word_q <= rdata;
        end
    end

    // store transition commits on this edge
    assign wr_en = (op_nxt == ST_WRITE);

    // outputs from the present state
    always_comb begin
        bus_oe  = 1'b0;
        bus_out = '0;
        unique case (state_q)
            ST_READ: begin
                bus_oe  = 1'b1;
                bus_out = word_q;
            end
            ST_OFF, ST_IDLE, ST_WRITE: begin
                bus_oe  = 1'b0;
                bus_out = '0;
            end
            default: begin
                bus_oe  = 1'b0;
                bus_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/mselect_sram.sv
module mselect_sram
    import msram_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int NUM_SEL_P = 2,
    parameter int NUM_SEL_N = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_SEL_P-1:0] sel_p,
    input  logic [NUM_SEL_N-1:0] sel_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [DATA_W-1:0]    bus_in,
    output logic [DATA_W-1:0]    bus_out,
    output logic                 bus_oe
);

    op_state_e         op_nxt;
    logic              wr_en;
    logic [DATA_W-1:0] rdata;

    msram_decode #(
        .NUM_SEL_P (NUM_SEL_P),
        .NUM_SEL_N (NUM_SEL_N)
    ) u_decode (
        .sel_p (sel_p),
        .sel_n (sel_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .op    (op_nxt)
    );

    msram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .we    (wr_en),
        .addr  (addr),
        .wdata (bus_in),
        .rdata (rdata)
    );

    msram_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_nxt  (op_nxt),
        .rdata   (rdata),
        .wr_en   (wr_en),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

endmodule

// File: rtl/mselect_sram_chk.sv
module mselect_sram_chk #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int NUM_SEL_P = 2,
    parameter int NUM_SEL_N = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_SEL_P-1:0] sel_p,
    input logic [NUM_SEL_N-1:0] sel_n,
    input logic                 rd_n,
    input logic [DATA_W-1:0]    bus_out,
    input logic                 bus_oe
);

    logic armed;
    logic on_now;
    logic rd_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    assign on_now = (&sel_p) && !(|sel_n);
    assign rd_now = on_now && !rd_n;

    // R3
    desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on_now |=> !bus_oe);

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |=> bus_oe);

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_now && rd_n) |=> !bus_oe);

    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (rd_now && $past(rd_now) && (addr == $past(addr))) |=> $stable(bus_out));

endmodule

bind mselect_sram mselect_sram_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_SEL_P (NUM_SEL_P),
    .NUM_SEL_N (NUM_SEL_N)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .sel_p   (sel_p),
    .sel_n   (sel_n),
    .rd_n    (rd_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
);

// File: tb/sim_mselect_sram.sv
module sim_mselect_sram;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic [1:0] sel_p = 2'b11;
    logic [2:0] sel_n = 3'b000;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mselect_sram u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .sel_p   (sel_p),
        .sel_n   (sel_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    // layout: [30:29] sel_p, [28:26] sel_n, [25] rd_n, [24] wr_n,
    //         [23:17] addr, [16:9] bus_in, [8] expected oe, [7:0] expected out
    localparam int NV = 18;
    localparam logic [30:0] VEC [NV] = '{
        {2'b11, 3'b000, 1'b1, 1'b0, 7'h05, 8'hA5, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b1, 1'b0, 7'h06, 8'h3C, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h05, 8'h00, 1'b1, 8'hA5},
        {2'b11, 3'b000, 1'b0, 1'b0, 7'h06, 8'hFF, 1'b1, 8'h3C},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h06, 8'h00, 1'b1, 8'h3C},
        {2'b10, 3'b000, 1'b1, 1'b0, 7'h05, 8'h11, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h05, 8'h00, 1'b1, 8'hA5},
        {2'b11, 3'b100, 1'b1, 1'b0, 7'h05, 8'h22, 1'b0, 8'h00},
        {2'b01, 3'b000, 1'b1, 1'b0, 7'h05, 8'h33, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h05, 8'h00, 1'b1, 8'hA5},
        {2'b11, 3'b000, 1'b1, 1'b1, 7'h05, 8'h44, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h05, 8'h00, 1'b1, 8'hA5},
        {2'b11, 3'b010, 1'b0, 1'b1, 7'h05, 8'h00, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b1, 1'b0, 7'h7F, 8'hC3, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b1, 1'b0, 7'h00, 8'h81, 1'b0, 8'h00},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h7F, 8'h00, 1'b1, 8'hC3},
        {2'b11, 3'b000, 1'b0, 1'b1, 7'h00, 8'h00, 1'b1, 8'h81},
        {2'b11, 3'b000, 1'b1, 1'b1, 7'h00, 8'h00, 1'b0, 8'h00}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 13, 14: return "R5 store";
            2:            return "R4 fetch";
            3, 4:         return "R6 read priority";
            5, 6, 12:     return "R3 deselect";
            7, 8, 9:      return "R2 select polarity";
            10, 11:       return "R7 standby";
            15, 16:       return "R9 address follow";
            default:      return "R8 quiet bus";
        endcase
    endfunction

    task automatic check(string tag, logic exp_oe, logic [7:0] exp_out);
        checks++;
        if (bus_oe !== exp_oe || bus_out !== exp_out) begin
            fails++;
            $display("FAIL %s: oe=%0b out=%02h expected oe=%0b out=%02h",
                     tag, bus_oe, bus_out, exp_oe, exp_out);
        end
    endtask

    task automatic drive(logic [1:0] p, logic [2:0] n, logic r, logic w,
                         logic [6:0] a, logic [7:0] d);
        sel_p  = p;
        sel_n  = n;
        rd_n   = r;
        wr_n   = w;
        addr   = a;
        bus_in = d;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [30:0] v;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            drive(v[30:29], v[28:26], v[25], v[24], v[23:17], v[16:9]);
            @(negedge clk);
            check(tag_of(i), v[8], v[7:0]);
        end

        // R9: nothing visible before the sampling edge
        drive(2'b11, 3'b000, 1'b0, 1'b1, 7'h05, 8'h00);
        #5;
        check("R9 latency pre-edge", 1'b0, 8'h00);
        @(negedge clk);
        check("R9 latency post-edge", 1'b1, 8'hA5);
        @(negedge clk);
        check("R9 hold", 1'b1, 8'hA5);

        // R10: reset during a read, contents kept
        rst_n = 1'b0;
        #5;
        check("R1 async reset", 1'b0, 8'h00);
        @(negedge clk);
        drive(2'b11, 3'b000, 1'b0, 1'b1, 7'h06, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 word kept over reset", 1'b1, 8'h3C);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule